// File: doc/BRIEF.md
# Byte-Bus 16-Bit Reloading Timer

This block is an up-counting timer whose double-width count and reload value sit behind a narrow register bus. A host reaches them one byte at a time. The block keeps those byte accesses coherent in both directions:

- **Reads.** Fetching the upper count byte freezes a copy of the lower byte. A follow-up read of the lower byte then matches the upper byte already taken, even though the counter kept moving.
- **Reload writes.** The upper reload byte is parked in a staging register. The full reload value changes in one step, when the lower byte arrives.

While enabled, the counter advances once per clock. When it equals the reload value, it restarts at one on the next clock and raises a single-cycle terminal-count flag. Count bytes can also be written directly. Such a write overrides counting for the byte it targets during that cycle.

Top module: `byte_timer`

## Requirements
- R1: After reset the count reads high byte 0x00 and low byte 0x01 (value 1), the reload value and its staging byte are zero, and `tc` is low.
- R2: While `en` is high and no count byte is written, the count grows by one per clock, modulo 2^(2·DW).
- R3: If the count equals the reload value at a clock edge while `en` is high and no count byte is written, the count becomes 1 at that edge and `tc` is high for exactly the following cycle. `tc` is low in every other cycle.
- R4: While `en` is low, the count does not change unless written, and a read at offset 1 returns the live low byte.
- R5: While `en` is high, a read at offset 0 returns the live high byte and copies the live low byte into a holding byte. A read at offset 1 returns that holding byte.
- R6: A write at offset 0 (high) or offset 1 (low) places `wdata` in that count byte at the next edge. The other byte keeps its value, with no increment or carry in that cycle. Counting then resumes from the new value.
- R7: A write at offset 2 only updates the staging byte. Reads at offset 2 and offset 3 keep returning the committed reload bytes.
- R8: A write at offset 3 sets the reload value to {staging byte, `wdata`} at the next edge.
- R9: `rdata` is zero when `rd` is low, and a read at any offset from 4 upward returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable |
| addr | input | AW | Register offset: 0 count high, 1 count low, 2 reload high, 3 reload low |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | DW | Write byte |
| rdata | output | DW | Read byte (combinational from `addr`/`rd`) |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench builds the timer with DW=4 and AW=3. This gives an 8-bit counter that the bench can drive through every one of its 256 reload values, with a wrap and terminal pulse for each. With AW=3 the bus has four unused offsets, so the zero readback of R9 can be checked. Every cycle is compared against an arithmetic model of count, holding byte, staging byte and reload value. Directed steps cover count writes that collide with a carry, and reads while the timer is stopped.

// File: rtl/byte_timer.sv
module byte_timer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tc
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] OFS_CH = AW'(0);
  localparam logic [AW-1:0] OFS_CL = AW'(1);
  localparam logic [AW-1:0] OFS_RH = AW'(2);
  localparam logic [AW-1:0] OFS_RL = AW'(3);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [DW-1:0] cnt_hi, cnt_lo, rel_hi, rel_lo, stage, hold;
  logic [CW-1:0] cnt;
  logic wr_ch, wr_cl, cnt_wr, at_rel;

  assign cnt    = {cnt_hi, cnt_lo};
  assign wr_ch  = wr && addr == OFS_CH;
  assign wr_cl  = wr && addr == OFS_CL;
  assign cnt_wr = wr_ch || wr_cl;
  assign at_rel = cnt == {rel_hi, rel_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_hi <= '0;
      cnt_lo <= DW'(1);
      rel_hi <= '0;
      rel_lo <= '0;
      stage  <= '0;
      hold   <= '0;
      tc     <= 1'b0;
    end else begin
      if (cnt_wr) begin
        if (wr_ch) cnt_hi <= wdata;
        if (wr_cl) cnt_lo <= wdata;
      end else if (en) begin
        {cnt_hi, cnt_lo} <= at_rel ? ONE : cnt + ONE;
      end
      tc <= en && !cnt_wr && at_rel;
      if (wr && addr == OFS_RH) stage <= wdata;
      if (wr && addr == OFS_RL) begin
        rel_hi <= stage;
        rel_lo <= wdata;
      end
      if (rd && en && addr == OFS_CH) hold <= cnt_lo;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        OFS_CH:  rdata = cnt_hi;
        OFS_CL:  rdata = en ? hold : cnt_lo;
        OFS_RH:  rdata = rel_hi;
        OFS_RL:  rdata = rel_lo;
        default: rdata = '0;
      endcase
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !cnt_wr && !at_rel |=> cnt == $past(cnt) + ONE);
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !cnt_wr && at_rel |=> cnt == ONE && tc);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !cnt_wr |=> $stable(cnt));
  // R6
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cl |=> cnt_lo == $past(wdata) && $stable(cnt_hi));
  // R7
  staged_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == OFS_RH |=> $stable(rel_hi) && $stable(rel_lo));
  // R8
  reload_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == OFS_RL |=> {rel_hi, rel_lo} == {$past(stage), $past(wdata)});
endmodule

// File: tb/byte_timer_bench.sv
module byte_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic tc;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_cnt = 8'h01;
  logic [7:0] m_rel = 8'h00;
  logic [3:0] m_stage = '0;
  logic [3:0] m_hold = '0;
  logic m_tc = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_timer #(.DW(4), .AW(3)) u_byte_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .tc(tc));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic w, input logic r,
                      input logic [2:0] a, input logic [3:0] d, input string tag);
    logic [3:0] exp_rd;
    logic [7:0] nc;
    logic nt;
    @(negedge clk);
    en = e; wr = w; rd = r; addr = a; wdata = d;
    #1;
    if (r) begin
      case (a)
        3'd0: exp_rd = m_cnt[7:4];
        3'd1: exp_rd = e ? m_hold : m_cnt[3:0];
        3'd2: exp_rd = m_rel[7:4];
        3'd3: exp_rd = m_rel[3:0];
        default: exp_rd = 4'h0;
      endcase
      check(rdata == exp_rd, tag, rdata, exp_rd);
    end else begin
      check(rdata == 4'h0, "R9", rdata, 0);
    end
    @(posedge clk);
    nc = m_cnt;
    nt = 1'b0;
    if (w && a == 3'd0) nc = {d, m_cnt[3:0]};
    else if (w && a == 3'd1) nc = {m_cnt[7:4], d};
    else if (e) begin
      if (m_cnt == m_rel) begin nc = 8'h01; nt = 1'b1; end
      else nc = m_cnt + 8'h01;
    end
    if (r && e && a == 3'd0) m_hold = m_cnt[3:0];
    if (w && a == 3'd3) m_rel = {m_stage, d};
    if (w && a == 3'd2) m_stage = d;
    m_cnt = nc;
    m_tc = nt;
    #1;
    check(tc == m_tc, "R3", tc, m_tc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(tc == 1'b0, "R1", tc, 0);
    step(0, 0, 1, 3'd0, 4'h0, "R1");
    step(0, 0, 1, 3'd1, 4'h0, "R1");
    step(0, 0, 1, 3'd2, 4'h0, "R1");
    step(0, 0, 1, 3'd3, 4'h0, "R1");

    for (int r = 0; r < 256; r++) begin
      logic [7:0] rv;
      logic [7:0] v;
      rv = 8'(r);
      v = rv - 8'd5;
      step(0, 1, 0, 3'd2, rv[7:4], "R7");
      step(0, 0, 1, 3'd2, 4'h0, "R7");
      step(0, 1, 0, 3'd3, rv[3:0], "R8");
      step(0, 0, 1, 3'd2, 4'h0, "R8");
      step(0, 0, 1, 3'd3, 4'h0, "R8");
      step(0, 1, 0, 3'd0, v[7:4], "R6");
      step(0, 1, 0, 3'd1, v[3:0], "R6");
      step(0, 0, 1, 3'd1, 4'h0, "R4");
      for (int k = 0; k < 8; k++)
        step(1, 0, 1, (k % 2 == 0) ? 3'd0 : 3'd1, 4'h0, (k % 2 == 0) ? "R2" : "R5");
    end

    for (int a = 4; a < 8; a++) step(0, 0, 1, 3'(a), 4'h0, "R9");

    step(0, 1, 0, 3'd0, 4'h2, "R6");
    step(0, 1, 0, 3'd1, 4'hF, "R6");
    step(1, 1, 0, 3'd0, 4'h5, "R6");
    step(0, 0, 1, 3'd0, 4'h0, "R6");
    step(0, 0, 1, 3'd1, 4'h0, "R6");
    step(1, 1, 0, 3'd1, 4'hE, "R6");
    step(1, 0, 0, 3'd0, 4'h0, "R2");
    step(1, 0, 0, 3'd0, 4'h0, "R2");
    step(1, 0, 1, 3'd0, 4'h0, "R5");
    step(1, 0, 0, 3'd0, 4'h0, "R5");
    step(1, 0, 1, 3'd1, 4'h0, "R5");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 3'd1, 4'h0, "R4");
    step(0, 0, 1, 3'd0, 4'h0, "R4");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule